// File: doc/BRIEF.md
# Point-Sample Shape Compositing Cell

This cell is one processing element of a two-dimensional systolic rasterizer. Its sample position is fixed by parameters. A stream of tagged coefficient sets arrives on a valid/data interface. The cell evaluates the quadratic `p = a*x^2 + b*y^2 + c*x + d*y + e` at its own point for every entry.

Shape entries turn the sign of `p` into a region test and fold it into a one-bit mask. The fold is a fresh start, a union or an intersection. Colour entries evaluate one polynomial per colour channel and stage the value, clamped to eight bits. A paint entry copies the staged colour into the stored pixel, but only where the mask is set, and then empties the mask. A stream of shapes, colours and paints therefore builds an image layer by layer.

Every entry, whatever its tag, passes to the neighbouring cell one clock later with its data unchanged. An array of these cells works as a pipeline in this way.

A small control state machine tracks the phase of the stream and gates the colour and pixel writes. It has three states:

- `PH_IDLE` (code 0). This is the state after reset, after a clear and after a paint.
- `PH_SHAPE` (code 1). The state machine enters it on any shape entry.
- `PH_COLOR` (code 2). The state machine enters it on any colour entry.

The transitions are:

- `clr` goes to `PH_IDLE`.
- Any shape tag goes to `PH_SHAPE`.
- Any colour tag goes to `PH_COLOR`.
- A paint tag goes to `PH_IDLE`.
- Anything else holds the state.

Top module: `shape_paint_cell`

## Requirements
- R1: Each cycle with `in_valid` high gives `out_valid` high one clock later, with `out_tag` and `out_coef` equal to the inputs of that cycle. A cycle with `in_valid` low gives `out_valid` low one clock later.
- R2: `in_coef` packs five signed coefficients: a in the top field, then b, c, d, and e in the lowest field. The sample point is inside a shape when `p` is strictly negative; `p` equal to 0 counts as outside.
- R3: Tag 0 (first shape) sets the mask to the inside result.
- R4: Tag 1 (union) sets the mask to the old mask OR the inside result.
- R5: Tag 2 (intersection) sets the mask to the old mask AND the inside result.
- R6: Tags 3, 4 and 5 stage the red, green and blue value as `p` clamped to 0..255. A negative `p` stores 0, and a `p` above 255 stores 255.
- R7: Tag 6 (paint) copies all three staged values into the pixel when the mask is set and leaves the pixel unchanged otherwise. In both cases the mask is then cleared. No other entry changes the pixel.
- R8: Tag 7 is forwarded per R1 but changes neither the mask, the pixel nor the phase.
- R9: `clr` high sets the pixel to 0, the mask to 0 and the phase to 0. This takes priority over an entry in the same cycle, which is still forwarded.
- R10: After reset, the pixel is 0, the mask is 0, the phase is 0 and `out_valid` is low.
- R11: With `in_valid` low, `in_tag` and `in_coef` have no effect on the mask, the pixel or the phase.
- R12: `phase` reads 0 (`PH_IDLE`), 1 (`PH_SHAPE`) or 2 (`PH_COLOR`) following the transitions above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clear the pixel, the mask and the phase |
| in_valid | input | 1 | The stream entry is valid |
| in_tag | input | 3 | Entry tag |
| in_coef | input | 5*COEF_W | Packed coefficients {a,b,c,d,e} |
| out_valid | output | 1 | Forwarded valid |
| out_tag | output | 3 | Forwarded tag |
| out_coef | output | 5*COEF_W | Forwarded coefficients |
| mask | output | 1 | Current shape mask |
| phase | output | 2 | Control state code |
| pix_r | output | 8 | Stored red |
| pix_g | output | 8 | Stored green |
| pix_b | output | 8 | Stored blue |

## Verification
The bench hits the sign boundary, where `p` equal to 0 must read as outside; a design testing `<= 0` would grow every shape by its edge. It drives colour values just below 0 and just above 255. A clamp that was missing or off by one would wrap a dark or saturated colour into a wrong value. It paints with an empty mask, paints twice in a row, and raises `clr` together with a paint. A design that ignored the mask, kept the mask after painting, or let the entry win over the clear would leave a visibly wrong pixel. Tag 7 entries and invalid cycles carrying a paint tag are mixed into a seeded random stream, so any decode that ignores the valid or the tag leaks into the mask or the pixel.

// File: rtl/shape_cell_pkg.sv
package shape_cell_pkg;

    localparam int TAG_W    = 3;
    localparam int CHAN_W   = 8;
    localparam int NUM_CHAN = 3;
    localparam int NUM_COEF = 5;

    typedef enum logic [TAG_W-1:0] {
        TAG_SHAPE_FIRST = 3'd0,
        TAG_SHAPE_OR    = 3'd1,
        TAG_SHAPE_AND   = 3'd2,
        TAG_COLOR_R     = 3'd3,
        TAG_COLOR_G     = 3'd4,
        TAG_COLOR_B     = 3'd5,
        TAG_PAINT       = 3'd6,
        TAG_NOP         = 3'd7
    } tag_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHAPE = 2'd1,
        PH_COLOR = 2'd2
    } phase_e;

endpackage

// File: rtl/conic_eval.sv
module conic_eval #(
    parameter int COEF_W  = 12,
    parameter int COORD_W = 4,
    parameter int X_POS   = 3,
    parameter int Y_POS   = 5,
    parameter int RES_W   = COEF_W + 2*COORD_W + 3
) (
    input  logic [shape_cell_pkg::NUM_COEF*COEF_W-1:0] coef,
    output logic signed [RES_W-1:0]                    value,
    output logic                                       in_region
);
    import shape_cell_pkg::*;

    localparam logic signed [RES_W-1:0] XR = RES_W'(X_POS);
    localparam logic signed [RES_W-1:0] YR = RES_W'(Y_POS);
    localparam logic signed [RES_W-1:0] XX = RES_W'(X_POS * X_POS);
    localparam logic signed [RES_W-1:0] YY = RES_W'(Y_POS * Y_POS);

    logic signed [RES_W-1:0] ext [NUM_COEF];

    // Sign-extend each field; field 0 (a) sits in the top bits.
    for (genvar k = 0; k < NUM_COEF; k++) begin : g_ext
        logic [COEF_W-1:0] raw;
        assign raw    = coef[(NUM_COEF-1-k)*COEF_W +: COEF_W];
        assign ext[k] = {{(RES_W-COEF_W){raw[COEF_W-1]}}, raw};
    end

    always_comb begin
        value     = ext[0]*XX + ext[1]*YY + ext[2]*XR + ext[3]*YR + ext[4];
        in_region = value[RES_W-1];
    end

endmodule

// File: rtl/chan_clamp.sv
module chan_clamp #(
    parameter int RES_W  = 23,
    parameter int CHAN_W = 8
) (
    input  logic signed [RES_W-1:0] value,
    output logic [CHAN_W-1:0]       chan
);
    localparam logic signed [RES_W-1:0] TOP = RES_W'((1 << CHAN_W) - 1);

    always_comb begin
        if (value[RES_W-1])
            chan = '0;
        else if (value > TOP)
            chan = '1;
        else
            chan = value[CHAN_W-1:0];
    end

endmodule

// File: rtl/cell_ctrl.sv
module cell_ctrl (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                in_valid,
    input  logic [shape_cell_pkg::TAG_W-1:0]    in_tag,
    input  logic                                in_region,
    output logic                                mask,
    output shape_cell_pkg::phase_e              phase,
    output logic [shape_cell_pkg::NUM_CHAN-1:0] col_we,
    output logic                                pix_we
);
    import shape_cell_pkg::*;

    phase_e phase_nxt;
    logic   mask_nxt;
    tag_e   tag;

    assign tag = tag_e'(in_tag);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            mask  <= 1'b0;
        end else begin
            phase <= phase_nxt;
            mask  <= mask_nxt;
        end
    end

    // Next state and write enables
    always_comb begin
        phase_nxt = phase;
        mask_nxt  = mask;
        col_we    = '0;
        pix_we    = 1'b0;
        if (clr) begin
            phase_nxt = PH_IDLE;
            mask_nxt  = 1'b0;
        end else if (in_valid) begin
            unique case (tag)
                TAG_SHAPE_FIRST: begin
                    phase_nxt = PH_SHAPE;
                    mask_nxt  = in_region;
                end
                TAG_SHAPE_OR: begin
                    phase_nxt = PH_SHAPE;
                    mask_nxt  = mask | in_region;
                end
                TAG_SHAPE_AND: begin
                    phase_nxt = PH_SHAPE;
                    mask_nxt  = mask & in_region;
                end
                TAG_COLOR_R: begin
                    phase_nxt = PH_COLOR;
                    col_we[0] = 1'b1;
                end
                TAG_COLOR_G: begin
                    phase_nxt = PH_COLOR;
                    col_we[1] = 1'b1;
                end
                TAG_COLOR_B: begin
                    phase_nxt = PH_COLOR;
                    col_we[2] = 1'b1;
                end
                TAG_PAINT: begin
                    phase_nxt = PH_IDLE;
                    mask_nxt  = 1'b0;
                    pix_we    = mask;
                end
                TAG_NOP: ;
                default: ;
            endcase
        end
    end

    assert_paint_clears_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tag == TAG_PAINT) |=> !mask);

    assert_clear_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!mask && phase == PH_IDLE));

    assert_nop_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tag == TAG_NOP && !clr) |=> ($stable(mask) && $stable(phase)));

    assert_and_narrows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tag == TAG_SHAPE_AND && !clr && !mask) |=> !mask);

    assert_idle_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> ($stable(mask) && $stable(phase)));

endmodule

// File: rtl/shape_paint_cell.sv
module shape_paint_cell #(
    parameter int COEF_W  = 12,
    parameter int COORD_W = 4,
    parameter int X_POS   = 3,
    parameter int Y_POS   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic [2:0]           in_tag,
    input  logic [5*COEF_W-1:0]  in_coef,
    output logic                 out_valid,
    output logic [2:0]           out_tag,
    output logic [5*COEF_W-1:0]  out_coef,
    output logic                 mask,
    output logic [1:0]           phase,
    output logic [7:0]           pix_r,
    output logic [7:0]           pix_g,
    output logic [7:0]           pix_b
);
    import shape_cell_pkg::*;

    localparam int RES_W = COEF_W + 2*COORD_W + 3;

    logic signed [RES_W-1:0] poly;
    logic                    in_region;
    logic [CHAN_W-1:0]       clamped;
    logic [NUM_CHAN-1:0]     col_we;
    logic                    pix_we;
    phase_e                  phase_q;
    logic [CHAN_W-1:0]       pix [NUM_CHAN];

    conic_eval #(
        .COEF_W(COEF_W), .COORD_W(COORD_W),
        .X_POS(X_POS), .Y_POS(Y_POS), .RES_W(RES_W)
    ) u_eval (
        .coef(in_coef), .value(poly), .in_region(in_region)
    );

    chan_clamp #(.RES_W(RES_W), .CHAN_W(CHAN_W)) u_clamp (
        .value(poly), .chan(clamped)
    );

    cell_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_tag(in_tag), .in_region(in_region),
        .mask(mask), .phase(phase_q), .col_we(col_we), .pix_we(pix_we)
    );

    assign phase = phase_q;

    // Per-channel colour stage and stored pixel
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        logic [CHAN_W-1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
                pix[ch] <= '0;
            end else begin
                if (col_we[ch])
                    stage_q <= clamped;
                if (clr)
                    pix[ch] <= '0;
                else if (pix_we)
                    pix[ch] <= stage_q;
            end
        end
    end

    assign pix_r = pix[0];
    assign pix_g = pix[1];
    assign pix_b = pix[2];

    // Forwarding stage to the neighbour
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_coef  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_tag  <= in_tag;
                out_coef <= in_coef;
            end
        end
    end

    assert_fwd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_tag == $past(in_tag) && out_coef == $past(in_coef)));

    assert_pix_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_tag == TAG_PAINT) && !clr) |=> ($stable(pix_r) && $stable(pix_g) && $stable(pix_b)));

    assert_clear_pix_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pix_r == 8'd0 && pix_g == 8'd0 && pix_b == 8'd0));

endmodule

// File: tb/shape_paint_cell_tb_top.sv
`timescale 1ns/1ps
module shape_paint_cell_tb_top;

    localparam int CW = 12;
    localparam int XP = 3;
    localparam int YP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_tag = '0;
    logic [5*CW-1:0] in_coef = '0;
    logic          out_valid;
    logic [2:0]    out_tag;
    logic [5*CW-1:0] out_coef;
    logic          mask;
    logic [1:0]    phase;
    logic [7:0]    pix_r, pix_g, pix_b;

    int n_checks = 0;
    int n_err = 0;

    // Reference state
    int m_mask = 0;
    int m_phase = 0;
    int m_stage [3] = '{0, 0, 0};
    int m_pix [3] = '{0, 0, 0};

    always #2.5 clk = ~clk;

    shape_paint_cell #(.COEF_W(CW), .COORD_W(4), .X_POS(XP), .Y_POS(YP)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_tag(in_tag), .in_coef(in_coef), .out_valid(out_valid),
        .out_tag(out_tag), .out_coef(out_coef), .mask(mask), .phase(phase),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    function automatic logic [5*CW-1:0] pack(int a, int b, int c, int d, int e);
        return {CW'(a), CW'(b), CW'(c), CW'(d), CW'(e)};
    endfunction

    function automatic int field(logic [5*CW-1:0] v, int k);
        logic signed [CW-1:0] f;
        f = v[(4-k)*CW +: CW];
        return int'(f);
    endfunction

    function automatic int poly(logic [5*CW-1:0] v);
        return field(v,0)*XP*XP + field(v,1)*YP*YP + field(v,2)*XP + field(v,3)*YP + field(v,4);
    endfunction

    function automatic int clamp8(int p);
        if (p < 0) return 0;
        if (p > 255) return 255;
        return p;
    endfunction

    task automatic chk(string req, longint got, longint expv);
        n_checks++;
        if (got != expv) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next falling edge.
    task automatic step(logic v, logic [2:0] tag, logic [5*CW-1:0] cf, logic c);
        int p;
        in_valid = v; in_tag = tag; in_coef = cf; clr = c;
        p = poly(cf);
        if (c) begin
            m_mask = 0; m_phase = 0; m_pix = '{0, 0, 0};
        end else if (v) begin
            case (tag)
                3'd0: begin m_mask = (p < 0); m_phase = 1; end
                3'd1: begin m_mask = m_mask | (p < 0); m_phase = 1; end
                3'd2: begin m_mask = m_mask & (p < 0); m_phase = 1; end
                3'd3, 3'd4, 3'd5: begin m_stage[tag-3] = clamp8(p); m_phase = 2; end
                3'd6: begin
                    if (m_mask != 0) m_pix = m_stage;
                    m_mask = 0; m_phase = 0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        chk("R1 out_valid", out_valid, v);
        if (v) begin
            chk("R1 out_tag", out_tag, tag);
            chk("R1 out_coef", out_coef, cf);
        end
        chk("mask R3 R4 R5 R7 R8 R9 R11", mask, m_mask);
        chk("phase R12", phase, m_phase);
        chk("pix_r R6 R7 R9", pix_r, m_pix[0]);
        chk("pix_g R6 R7 R9", pix_g, m_pix[1]);
        chk("pix_b R6 R7 R9", pix_b, m_pix[2]);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c311));
        repeat (3) @(negedge clk);
        // R10: state right after reset
        chk("R10 out_valid", out_valid, 0);
        chk("R10 mask", mask, 0);
        chk("R10 phase", phase, 0);
        chk("R10 pix", {pix_r, pix_g, pix_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 boundary: p = 9-10 = -1 is inside, p = 0 is outside
        step(1, 3'd0, pack(1, 0, 0, 0, -10), 0);
        chk("R2 inside at p=-1", mask, 1);
        step(1, 3'd0, pack(1, 0, 0, 0, -9), 0);
        chk("R2 outside at p=0", mask, 0);
        // R4 union, R5 intersection
        step(1, 3'd1, pack(0, 0, 0, 0, -1), 0);
        chk("R4 union sets", mask, 1);
        step(1, 3'd2, pack(0, 0, 0, 0, 5), 0);
        chk("R5 intersection clears", mask, 0);
        // R6 clamping: -1 -> 0, 256 -> 255, 255 exact
        step(1, 3'd3, pack(0, 0, 0, 0, -1), 0);
        step(1, 3'd4, pack(0, 0, 0, 0, 256), 0);
        step(1, 3'd5, pack(0, 0, 0, 0, 255), 0);
        // R7 paint with empty mask leaves black
        step(1, 3'd6, '0, 0);
        chk("R7 empty mask keeps pixel", {pix_r, pix_g, pix_b}, 0);
        // R7 paint with mask set
        step(1, 3'd0, pack(0, 0, 0, 0, -3), 0);
        step(1, 3'd6, '0, 0);
        chk("R6 R7 painted colour", {pix_r, pix_g, pix_b}, {8'd0, 8'd255, 8'd255});
        chk("R7 mask cleared", mask, 0);
        // R7 second paint in a row does nothing
        step(1, 3'd3, pack(0, 0, 0, 0, 77), 0);
        step(1, 3'd6, '0, 0);
        chk("R7 repeat paint", pix_r, 0);
        // R8 tag 7 ignored; R11 invalid paint ignored
        step(1, 3'd0, pack(0, 0, 0, 0, -3), 0);
        step(1, 3'd7, pack(0, 0, 0, 0, 4), 0);
        chk("R8 nop keeps mask", mask, 1);
        step(0, 3'd6, '0, 0);
        chk("R11 invalid paint ignored", mask, 1);
        // R9 clear wins over paint in the same cycle
        step(1, 3'd6, '0, 1);
        chk("R9 clear beats paint", {pix_r, pix_g, pix_b}, 0);

        // Random stream
        for (int i = 0; i < 600; i++) begin
            logic v;
            logic c;
            logic [2:0] t;
            v = ($urandom_range(0, 9) != 0);
            c = ($urandom_range(0, 39) == 0);
            t = 3'($urandom_range(0, 7));
            step(v, t, pack($urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8,
                            $urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8,
                            $urandom_range(0, 700) - 300), c);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule